// File: doc/BRIEF.md
# Multi-channel SAR scan sequencer

This block is the digital side of a 12-bit successive-approximation converter with up to eight analog inputs. A bitmask picks which inputs take part in a scan. A scan can be started by a software go bit, by a pulse from a timer, or by a pulse on an external trigger line. For each enabled input, in ascending order, the block points the analog multiplexer at it and pulses that input's sample-and-hold strobe. It then walks the twelve bits of a DAC code from the most significant bit down, keeping each trial bit while the comparator reports that the held input is at or above the DAC level. The final code goes into the result register of that input.

Each input takes a fixed slot of 50 clocks: 12 for sampling, 36 for the bit search (three clocks per bit) and 2 for storing the result. Inputs 0 to 2 form a group that is sampled together at the start of the first group slot. The converter can make one pass and stop, or keep repeating passes until software clears the go bit. Each finished pass sets a sticky interrupt flag and gives a one-cycle DMA request pulse. The analog parts (multiplexer, hold capacitors, DAC and comparator) sit outside the block.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, go_flag, eoc_irq and dma_req are low, dac_code is 0, and every result register reads 0.
- R2: Each result is the 12-bit code found by testing bits from MSB to LSB, keeping a bit when cmp_ge is 1. With an ideal comparator this gives the held input value, from 0 up to 4095.
- R3: Enabled inputs are converted once per pass in ascending index order. mux_sel holds the index of the input being converted, and any strobe bit that is high includes the bit for mux_sel.
- R4: Each enabled input takes exactly 50 clocks, so eoc_irq rises 50*N clocks after the clock edge that accepted the start, where N is the number of enabled inputs.
- R5: While idle, a one-cycle pulse on sw_go_set, tmr_trig or ext_trig starts a pass if ch_mask is non-zero. With a zero mask the pulse is ignored.
- R6: With cont_mode low, go_flag clears at the end of the single pass, and no further conversion follows.
- R7: With cont_mode high, passes repeat back to back (one DMA pulse every 50*N clocks) until a sw_go_clr pulse, after which go_flag is low in the next cycle and no further pass completes.
- R8: eoc_irq is set at the end of every pass and stays set until an irq_clr pulse. dma_req is high for exactly one cycle per pass, in the same cycle that eoc_irq is set.
- R9: Enabled inputs among 0..2 all strobe in one cycle, at the start of the first slot of a pass. Each input at index 3 or above strobes alone, at the start of its own slot.
- R10: Start pulses on any source that arrive while a pass is running have no effect: the pass length is unchanged and no extra pass follows in single mode.
- R11: Each result is written only into the register of the input it belongs to, read through rd_sel/rd_data. Registers of inputs not enabled keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_mask | input | NUM_CH | Enabled-input bitmask |
| cont_mode | input | 1 | 1 = repeating passes, 0 = single pass |
| sw_go_set | input | 1 | Software write of 1 to the go bit (pulse) |
| sw_go_clr | input | 1 | Software write of 0 to the go bit (pulse) |
| tmr_trig | input | 1 | Timer start pulse |
| ext_trig | input | 1 | External start pulse |
| irq_clr | input | 1 | Clears the end-of-pass flag |
| cmp_ge | input | 1 | Comparator: held input >= DAC level |
| rd_sel | input | log2(NUM_CH) | Result register select |
| rd_data | output | RES_BITS | Selected result |
| dac_code | output | RES_BITS | DAC trial code |
| mux_sel | output | log2(NUM_CH) | Analog multiplexer select |
| sh_strobe | output | NUM_CH | Per-input sample-and-hold strobe |
| go_flag | output | 1 | Go bit / busy |
| eoc_irq | output | 1 | Sticky end-of-pass interrupt |
| dma_req | output | 1 | One-cycle DMA request per pass |

## Verification
The bench changes every analog input one cycle after the first strobe of a pass. A design that sampled inputs 1 and 2 late, instead of together with the group, would return the changed values, and one that sampled the first input late would corrupt it. Full-scale, zero and mid-scale codes catch a reversed bit order or an inverted keep rule. The bench measures pass length and the spacing of repeated DMA pulses to catch a slot that is a clock short or long. It also fires start pulses in the middle of a scan, which would make a design that re-arms while busy run an extra pass or restart its counters.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   typedef enum logic [1:0] {
      PH_SAMPLE  = 2'd0,
      PH_CONVERT = 2'd1,
      PH_STORE   = 2'd2
   } slot_phase_e;
endpackage

// File: rtl/adc_slot_timer.sv
module adc_slot_timer
   import adc_scan_pkg::*;
#(
   parameter int SAMPLE_ST = 12,
   parameter int RES_BITS  = 12,
   parameter int PER_BIT   = 3,
   parameter int STORE_ST  = 2,
   localparam int SLOT     = SAMPLE_ST + RES_BITS * PER_BIT + STORE_ST,
   localparam int CW       = $clog2(SLOT),
   localparam int BW       = $clog2(RES_BITS),
   localparam int SW       = $clog2(PER_BIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          clr_i,
   output slot_phase_e   phase_o,
   output logic [SW-1:0] sub_o,
   output logic [BW-1:0] bit_o,
   output logic          first_o,
   output logic          store_o,
   output logic          end_o
);
   localparam logic [CW-1:0] CONV_LO  = CW'(SAMPLE_ST);
   localparam logic [CW-1:0] STORE_AT = CW'(SAMPLE_ST + RES_BITS * PER_BIT);
   localparam logic [CW-1:0] LAST_ST  = CW'(SLOT - 1);
   localparam logic [BW-1:0] TOP_BIT  = BW'(RES_BITS - 1);
   localparam logic [SW-1:0] SUB_LAST = SW'(PER_BIT - 1);

   logic [CW-1:0] cnt_q;
   logic [SW-1:0] sub_q;
   logic [BW-1:0] bit_q;

   always_comb begin
      if (cnt_q < CONV_LO)       phase_o = PH_SAMPLE;
      else if (cnt_q < STORE_AT) phase_o = PH_CONVERT;
      else                       phase_o = PH_STORE;
   end

   assign first_o = (cnt_q == '0);
   assign store_o = (cnt_q == STORE_AT);
   assign end_o   = (cnt_q == LAST_ST);
   assign sub_o   = sub_q;
   assign bit_o   = bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sub_q <= '0;
         bit_q <= TOP_BIT;
      end else if (clr_i || !run_i) begin
         cnt_q <= '0;
         sub_q <= '0;
         bit_q <= TOP_BIT;
      end else if (end_o) begin
         cnt_q <= '0;
         sub_q <= '0;
         bit_q <= TOP_BIT;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (phase_o == PH_CONVERT) begin
            if (sub_q == SUB_LAST) begin
               sub_q <= '0;
               if (bit_q != '0) bit_q <= bit_q - 1'b1;
            end else begin
               sub_q <= sub_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
   parameter int RES_BITS = 12,
   parameter int PER_BIT  = 3,
   localparam int BW      = $clog2(RES_BITS),
   localparam int SW      = $clog2(PER_BIT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                conv_i,
   input  logic [SW-1:0]       sub_i,
   input  logic [BW-1:0]       bit_i,
   input  logic                cmp_ge_i,
   output logic [RES_BITS-1:0] code_o
);
   localparam logic [SW-1:0] SUB_LAST = SW'(PER_BIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
      end else if (clear_i) begin
         code_o <= '0;
      end else if (conv_i) begin
         if (sub_i == '0)
            code_o[bit_i] <= 1'b1;
         else if (sub_i == SUB_LAST && !cmp_ge_i)
            code_o[bit_i] <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_ch_picker.sv
module adc_ch_picker #(
   parameter int NUM_CH = 8,
   localparam int CHW   = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] mask_i,
   input  logic [CHW:0]      base_i,
   output logic [CHW-1:0]    sel_o,
   output logic              found_o
);
   always_comb begin
      sel_o   = '0;
      found_o = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mask_i[i] && (i >= int'(base_i))) begin
            sel_o   = CHW'(i);
            found_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int RES_BITS  = 12,
   parameter int SAMPLE_ST = 12,
   parameter int PER_BIT   = 3,
   parameter int STORE_ST  = 2,
   parameter int GROUP_CH  = 3,
   localparam int CHW      = $clog2(NUM_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   ch_mask,
   input  logic                cont_mode,
   input  logic                sw_go_set,
   input  logic                sw_go_clr,
   input  logic                tmr_trig,
   input  logic                ext_trig,
   input  logic                irq_clr,
   input  logic                cmp_ge,
   input  logic [CHW-1:0]      rd_sel,
   output logic [RES_BITS-1:0] rd_data,
   output logic [RES_BITS-1:0] dac_code,
   output logic [CHW-1:0]      mux_sel,
   output logic [NUM_CH-1:0]   sh_strobe,
   output logic                go_flag,
   output logic                eoc_irq,
   output logic                dma_req
);
   localparam int BW = $clog2(RES_BITS);
   localparam int SW = $clog2(PER_BIT);
   localparam logic [CHW:0] GRP_LIM = (CHW + 1)'(GROUP_CH);

   generate
      if (NUM_CH < 2 || (1 << CHW) != NUM_CH) begin : g_bad_nch
         $error("NUM_CH must be a power of two, at least 2");
      end
      if (GROUP_CH < 1 || GROUP_CH >= NUM_CH) begin : g_bad_grp
         $error("GROUP_CH must lie in 1..NUM_CH-1");
      end
      if (PER_BIT < 2 || STORE_ST < 2 || SAMPLE_ST < 1) begin : g_bad_slot
         $error("slot split needs PER_BIT>=2, STORE_ST>=2, SAMPLE_ST>=1");
      end
   endgenerate

   logic              run_q, first_pass_q, irq_q, dma_q;
   logic [CHW-1:0]    cur_q;
   logic [NUM_CH-1:0] pass_mask_q;

   slot_phase_e       phase;
   logic [SW-1:0]     sub;
   logic [BW-1:0]     bitn;
   logic              slot_first, slot_store, slot_end;

   logic [CHW-1:0]    new_ch, nxt_ch;
   logic              new_any, nxt_any;

   logic any_start, start_evt, stop_evt;
   assign any_start = sw_go_set | tmr_trig | ext_trig;
   assign start_evt = !run_q && any_start && new_any;
   assign stop_evt  = run_q && sw_go_clr;

   adc_ch_picker #(.NUM_CH(NUM_CH)) u_pick_first (
      .mask_i  (ch_mask),
      .base_i  ('0),
      .sel_o   (new_ch),
      .found_o (new_any)
   );

   adc_ch_picker #(.NUM_CH(NUM_CH)) u_pick_next (
      .mask_i  (pass_mask_q),
      .base_i  ({1'b0, cur_q} + 1'b1),
      .sel_o   (nxt_ch),
      .found_o (nxt_any)
   );

   adc_slot_timer #(
      .SAMPLE_ST (SAMPLE_ST),
      .RES_BITS  (RES_BITS),
      .PER_BIT   (PER_BIT),
      .STORE_ST  (STORE_ST)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run_q),
      .clr_i   (start_evt | stop_evt),
      .phase_o (phase),
      .sub_o   (sub),
      .bit_o   (bitn),
      .first_o (slot_first),
      .store_o (slot_store),
      .end_o   (slot_end)
   );

   adc_sar_core #(
      .RES_BITS (RES_BITS),
      .PER_BIT  (PER_BIT)
   ) u_sar (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (!run_q || slot_first),
      .conv_i   (phase == PH_CONVERT),
      .sub_i    (sub),
      .bit_i    (bitn),
      .cmp_ge_i (cmp_ge),
      .code_o   (dac_code)
   );

   logic pass_done;
   assign pass_done = run_q && slot_end && !nxt_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q        <= 1'b0;
         first_pass_q <= 1'b0;
         cur_q        <= '0;
         pass_mask_q  <= '0;
         dma_q        <= 1'b0;
      end else begin
         dma_q <= 1'b0;
         if (stop_evt) begin
            run_q <= 1'b0;
         end else if (start_evt) begin
            run_q        <= 1'b1;
            pass_mask_q  <= ch_mask;
            cur_q        <= new_ch;
            first_pass_q <= 1'b1;
         end else if (run_q && slot_end) begin
            first_pass_q <= 1'b0;
            if (nxt_any) begin
               cur_q <= nxt_ch;
            end else begin
               dma_q <= 1'b1;
               if (cont_mode && new_any) begin
                  pass_mask_q  <= ch_mask;
                  cur_q        <= new_ch;
                  first_pass_q <= 1'b1;
               end else begin
                  run_q <= 1'b0;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (pass_done) irq_q <= 1'b1;
      else if (irq_clr)   irq_q <= 1'b0;
   end

   logic [RES_BITS-1:0] res_q [NUM_CH];
   logic                in_group;
   assign in_group = ({1'b0, cur_q} < GRP_LIM);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            res_q[g] <= '0;
         else if (run_q && slot_store && cur_q == CHW'(g))
            res_q[g] <= dac_code;
      end
      if (g < GROUP_CH) begin : g_grp
         assign sh_strobe[g] = run_q && slot_first && first_pass_q && in_group
                               && pass_mask_q[g];
      end else begin : g_solo
         assign sh_strobe[g] = run_q && slot_first && (cur_q == CHW'(g));
      end
   end

   assign rd_data = res_q[rd_sel];
   assign mux_sel = cur_q;
   assign go_flag = run_q;
   assign eoc_irq = irq_q;
   assign dma_req = dma_q;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
   parameter int NUM_CH   = 8,
   parameter int GROUP_CH = 3,
   localparam int CHW     = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_go_set,
   input logic              tmr_trig,
   input logic              ext_trig,
   input logic              irq_clr,
   input logic              go_flag,
   input logic              eoc_irq,
   input logic              dma_req,
   input logic [NUM_CH-1:0] sh_strobe,
   input logic [CHW-1:0]    mux_sel
);
   // R9: strobes only while a pass runs
   a_r9_strobe_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_strobe != '0) |-> go_flag);

   // R9: inputs outside the group never share a strobe cycle
   a_r9_solo_outside_group: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sh_strobe[NUM_CH-1:GROUP_CH]));

   // R3: a strobe always covers the input the multiplexer points at
   a_r3_strobe_on_mux: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_strobe != '0) |-> sh_strobe[mux_sel]);

   // R8: the DMA request comes with the interrupt flag
   a_r8_dma_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> eoc_irq);

   // R8: the flag is sticky until cleared
   a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_irq && !irq_clr) |=> eoc_irq);

   // R8: one-cycle DMA pulse
   a_r8_dma_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |=> !dma_req);

   // R5: without a start pulse an idle sequencer stays idle
   a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_flag && !sw_go_set && !tmr_trig && !ext_trig) |=> !go_flag);
endmodule

bind adc_scan_ctrl adc_scan_chk #(
   .NUM_CH   (NUM_CH),
   .GROUP_CH (GROUP_CH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sw_go_set (sw_go_set),
   .tmr_trig  (tmr_trig),
   .ext_trig  (ext_trig),
   .irq_clr   (irq_clr),
   .go_flag   (go_flag),
   .eoc_irq   (eoc_irq),
   .dma_req   (dma_req),
   .sh_strobe (sh_strobe),
   .mux_sel   (mux_sel)
);

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 8;
   localparam int SLOT = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ch_mask = '0;
   logic        cont_mode = 1'b0;
   logic        sw_go_set = 1'b0, sw_go_clr = 1'b0;
   logic        tmr_trig = 1'b0, ext_trig = 1'b0, irq_clr = 1'b0;
   logic        cmp_ge;
   logic [2:0]  rd_sel = '0;
   logic [11:0] rd_data, dac_code;
   logic [2:0]  mux_sel;
   logic [7:0]  sh_strobe;
   logic        go_flag, eoc_irq, dma_req;

   logic [11:0] analog [NCH];
   logic [11:0] held   [NCH];
   logic [11:0] va     [NCH];
   logic [11:0] vb     [NCH];
   logic [11:0] exp_res[NCH];

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_scan_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ch_mask(ch_mask), .cont_mode(cont_mode),
      .sw_go_set(sw_go_set), .sw_go_clr(sw_go_clr), .tmr_trig(tmr_trig),
      .ext_trig(ext_trig), .irq_clr(irq_clr), .cmp_ge(cmp_ge), .rd_sel(rd_sel),
      .rd_data(rd_data), .dac_code(dac_code), .mux_sel(mux_sel),
      .sh_strobe(sh_strobe), .go_flag(go_flag), .eoc_irq(eoc_irq), .dma_req(dma_req)
   );

   // analog front end model: hold capacitors and ideal comparator
   always @(posedge clk) begin
      for (int i = 0; i < NCH; i++)
         if (sh_strobe[i]) held[i] <= analog[i];
   end
   assign cmp_ge = (held[mux_sel] >= dac_code);

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic read_res(input int c, output int v);
      rd_sel = 3'(c);
      #1;
      v = int'(rd_data);
   endtask

   task automatic fill(input bit corner);
      logic [11:0] cv [NCH];
      cv = '{12'd0, 12'd4095, 12'd2048, 12'd2047, 12'd1, 12'd4094, 12'd1365, 12'd2730};
      for (int i = 0; i < NCH; i++) begin
         va[i] = corner ? cv[i] : 12'($urandom % 4096);
         vb[i] = 12'($urandom % 4096);
      end
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk(eoc_irq == 1'b0, "R8 flag cleared by irq_clr", int'(eoc_irq), 0);
   endtask

   task automatic set_src(input int src, input logic v);
      case (src)
         0: sw_go_set = v;
         1: tmr_trig  = v;
         default: ext_trig = v;
      endcase
   endtask

   function automatic int first_of(input logic [7:0] m);
      for (int i = 0; i < NCH; i++) if (m[i]) return i;
      return -1;
   endfunction

   // single pass, checked end to end
   task automatic run_single(input logic [7:0] m, input int src, input bit poke, input bit corner);
      int cyc, n, fst, nord, ndma, v, k;
      bit seen, pend;
      logic [7:0] first_pat, exp_pat;
      int ord [16];
      fill(corner);
      clear_irq();
      for (int i = 0; i < NCH; i++) analog[i] = va[i];
      ch_mask = m; cont_mode = 1'b0;
      n = $countones(m); fst = first_of(m);
      @(negedge clk); set_src(src, 1'b1);
      cyc = 0; seen = 0; pend = 0; nord = 0; ndma = 0; first_pat = '0;
      while (!eoc_irq && cyc < 2000) begin
         @(negedge clk); cyc++;
         if (cyc == 1) set_src(src, 1'b0);
         if (pend) begin
            for (int i = 0; i < NCH; i++) analog[i] = vb[i];
            pend = 0;
         end
         if (sh_strobe != '0 && !seen) begin
            seen = 1; pend = 1; first_pat = sh_strobe;
         end
         if (go_flag && (nord == 0 || 3'(ord[nord-1]) != mux_sel) && nord < 16) begin
            ord[nord] = int'(mux_sel); nord++;
         end
         if (poke && cyc == 30) begin sw_go_set = 1; tmr_trig = 1; ext_trig = 1; end
         if (poke && cyc == 31) begin sw_go_set = 0; tmr_trig = 0; ext_trig = 0; end
         if (dma_req) ndma++;
      end
      // start edge precedes first negedge, so the flag shows at count 50*N+1 (R4, R10)
      chk(cyc == SLOT * n + 1, poke ? "R10 pass length with mid-scan triggers" : "R4 pass length",
          cyc, SLOT * n + 1);
      chk(go_flag == 1'b0, "R6 go bit cleared after single pass", int'(go_flag), 0);
      exp_pat = (m[2:0] != 0) ? {5'b0, m[2:0]} : 8'(1 << fst);
      chk(first_pat == exp_pat, "R9 first strobe pattern", int'(first_pat), int'(exp_pat));
      chk(nord == n, "R3 number of inputs visited", nord, n);
      k = 0;
      for (int i = 0; i < NCH; i++) begin
         if (m[i]) begin
            if (k < nord) chk(ord[k] == i, "R3 ascending order", ord[k], i);
            k++;
         end
      end
      for (int i = 0; i < 70; i++) begin
         @(negedge clk);
         if (dma_req) ndma++;
         if (go_flag) break;
      end
      chk(go_flag == 1'b0, poke ? "R10 no extra pass after triggers" : "R6 stays stopped",
          int'(go_flag), 0);
      chk(ndma == 1, "R8 one DMA pulse per pass", ndma, 1);
      chk(eoc_irq == 1'b1, "R8 flag sticky", int'(eoc_irq), 1);
      for (int i = 0; i < NCH; i++) begin
         if (m[i])
            exp_res[i] = ((i < 3 && m[2:0] != 0) || i == fst) ? va[i] : vb[i];
         read_res(i, v);
         chk(v == int'(exp_res[i]), m[i] ? "R2 R9 converted value" : "R11 untouched register",
             v, int'(exp_res[i]));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int v, nd, cyc, clr_at;
      int tp [3];
      void'($urandom(32'd7321));
      for (int i = 0; i < NCH; i++) begin analog[i] = '0; held[i] = '0; exp_res[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(go_flag == 0, "R1 go_flag after reset", int'(go_flag), 0);
      chk(eoc_irq == 0, "R1 eoc_irq after reset", int'(eoc_irq), 0);
      chk(dma_req == 0, "R1 dma_req after reset", int'(dma_req), 0);
      chk(dac_code == 0, "R1 dac_code after reset", int'(dac_code), 0);
      for (int i = 0; i < NCH; i++) begin
         read_res(i, v);
         chk(v == 0, "R1 result after reset", v, 0);
      end

      // R5 zero mask: every source ignored
      ch_mask = '0;
      for (int s = 0; s < 3; s++) begin
         @(negedge clk); set_src(s, 1'b1);
         @(negedge clk); set_src(s, 1'b0);
         @(negedge clk);
         chk(go_flag == 0, "R5 start with zero mask ignored", int'(go_flag), 0);
      end

      // directed corners (R2, R5 each source, R9 group, R11)
      run_single(8'hFF, 0, 1'b0, 1'b1);
      run_single(8'h80, 2, 1'b0, 1'b1);
      run_single(8'h05, 1, 1'b1, 1'b1);
      run_single(8'h1A, 1, 1'b0, 1'b0);

      // random passes
      for (int it = 0; it < 20; it++)
         run_single(8'($urandom % 255 + 1), int'($urandom % 3), (it % 4) == 0, 1'b0);

      // R7 continuous mode
      fill(1'b0);
      clear_irq();
      for (int i = 0; i < NCH; i++) analog[i] = va[i];
      ch_mask = 8'b1000_0110; cont_mode = 1'b1;
      @(negedge clk); sw_go_set = 1'b1;
      @(negedge clk); sw_go_set = 1'b0;
      nd = 0; cyc = 0; clr_at = -1;
      while (nd < 3 && cyc < 2000) begin
         @(negedge clk); cyc++;
         if (irq_clr) irq_clr = 1'b0;
         if (cyc == clr_at)
            chk(eoc_irq == 0, "R8 flag low after clear in continuous mode", int'(eoc_irq), 0);
         if (dma_req) begin
            tp[nd] = cyc; nd++;
            if (nd == 1) begin irq_clr = 1'b1; clr_at = cyc + 1; end
            if (nd == 2) chk(eoc_irq == 1, "R8 flag set again next pass", int'(eoc_irq), 1);
         end
      end
      chk(nd == 3, "R7 passes repeat", nd, 3);
      chk(tp[1] - tp[0] == 150, "R7 pass spacing", tp[1] - tp[0], 150);
      chk(tp[2] - tp[1] == 150, "R7 pass spacing", tp[2] - tp[1], 150);
      chk(go_flag == 1, "R7 still running", int'(go_flag), 1);
      @(negedge clk); sw_go_clr = 1'b1;
      @(negedge clk); sw_go_clr = 1'b0;
      chk(go_flag == 0, "R7 stop by go-bit clear", int'(go_flag), 0);
      nd = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (dma_req) nd++;
      end
      chk(nd == 0 && go_flag == 0, "R7 no pass after stop", nd, 0);
      exp_res[1] = va[1]; exp_res[2] = va[2]; exp_res[7] = va[7];
      for (int i = 0; i < NCH; i++) begin
         read_res(i, v);
         chk(v == int'(exp_res[i]), "R7 R11 results after continuous run", v, int'(exp_res[i]));
      end

      summary();
      $finish;
   end
endmodule